// File: doc/BRIEF.md
# Serial Management Slave with Bus Bridge

This block sits on the PHY side of a two-wire serial management link and turns each management frame it accepts into one access on a Wishbone classic bus. The serial input is sampled only on cycles where an external clock-enable strobe is high. One strobe marks one bit period of the management clock. A frame is accepted only after a long run of idle ones, a correct start pattern, a known opcode and a matching station address. A write frame becomes one bus write. A read frame starts one bus read as soon as its register address is complete, and the returned word is shifted back out serially together with an output-enable.

The bus side is built so that a faulty target cannot lock up the link. If the target answers a read with an error, or does not answer in time, the strobe is withdrawn and the serial line is left released for the whole reply. To the management master this looks like an absent device. The slave then returns to hunting for the next frame. Pad tri-state logic, management clock generation and extended-address frames are outside the block.

Top module: `mgmt_serial_bridge`

## Requirements
- R1: `mdi` is sampled, and `mdo`/`mdo_valid` change, only at clock edges where `ce` is high. Toggling `mdi` while `ce` is low has no effect.
- R2: A frame needs at least `PREAMBLE_MIN` (default 32) consecutive sampled ones before its start pattern. Any sampled zero resets the run, and a frame with only 31 leading ones causes no bus cycle and no driven reply.
- R3: The two bits after the preamble must be 0 then 1. Any other pair causes the frame to be ignored.
- R4: The two opcode bits 1,0 select read and 0,1 select write. The pairs 0,0 and 1,1 cause the frame to be ignored.
- R5: A 5-bit station address follows, MSB first. It must equal `PHY_ADDR` (default 0). Frames for any other address, for example 1 or 16, start no bus cycle and leave `mdo_valid` low.
- R6: A write frame continues with a 5-bit register address, two turnaround bits (their values are not checked) and 16 data bits, all MSB first. At the edge that samples the last data bit, `cyc`, `stb` and `we` go high with `addr` = register address and `data_write` = data. These values hold until the cycle ends.
- R7: For a read frame, `cyc` and `stb` go high with `we` low and `addr` = register address at the edge that samples the last address bit (strobe 0). On `ack`, `data_read` is captured.
- R8: Reply timing, counted in strobes after strobe 0: during period 0 `mdo_valid` is low. At strobe 1, `mdo_valid` rises with `mdo` = 0. At strobes 2 to 17 the 16 data bits appear MSB first. At strobe 18 `mdo_valid` falls.
- R9: If the read ends with `err`, or no `ack` has arrived by strobe 1, `mdo_valid` stays low for the whole reply.
- R10: A bus cycle ends at the edge after `ack` or `err`. It also ends on its own after `ACK_TIMEOUT` clock cycles without either, and a read also ends at strobe 1.
- R11: After a reply, a completed write or a rejected frame, the slave hunts for a new preamble. The next valid frame is served normally, including after error and time-out cases.
- R12: Synchronous active-high `rst` leaves `cyc`, `stb` and `mdo_valid` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ce | input | 1 | One-cycle strobe per management bit period |
| mdi | input | 1 | Serial management data in |
| mdo | output | 1 | Serial reply data |
| mdo_valid | output | 1 | Output enable for `mdo` |
| cyc | output | 1 | Bus cycle |
| stb | output | 1 | Bus strobe |
| we | output | 1 | Bus write enable |
| addr | output | 5 | Bus register address |
| data_write | output | 16 | Bus write data |
| data_read | input | 16 | Bus read data |
| ack | input | 1 | Bus acknowledge |
| err | input | 1 | Bus error response |

## Verification
The bench attacks the frame filter with a preamble one bit short, bad start pairs, both unused opcodes and foreign station addresses. A filter that is too lenient would show up as an extra bus cycle or a driven reply. Bus error and a silent target are both exercised. A bridge that ignored them would drive stale data, or leave `stb` high forever and never serve the next frame. It also feeds a complete frame with `ce` held low and toggles `mdi` between strobes, which catches any sampling on the wrong edges. Random write/read pairs with varied preamble lengths confirm the reply bit order and the one-zero lead-in slot.

// File: rtl/mgmt_bridge_pkg.sv
package mgmt_bridge_pkg;

    localparam int PHY_AW     = 5;
    localparam int REG_AW     = 5;
    localparam int DATA_W     = 16;
    localparam int RESP_SLOTS = DATA_W + 2;

    localparam logic [1:0] OP_RD = 2'b10;
    localparam logic [1:0] OP_WR = 2'b01;

    typedef enum logic [2:0] {
        S_HUNT,
        S_START,
        S_OP,
        S_PHY,
        S_REG,
        S_TA,
        S_WDATA,
        S_RESP
    } rx_state_e;

    typedef struct packed {
        logic              rd;
        logic              wr;
        logic [REG_AW-1:0] addr;
        logic [DATA_W-1:0] wdata;
    } bus_req_t;

    typedef struct packed {
        logic              ok;
        logic [DATA_W-1:0] data;
    } rd_result_t;

    function automatic logic op_known(input logic [1:0] op);
        return (op == OP_RD) || (op == OP_WR);
    endfunction

endpackage

// File: rtl/mgmt_frame_rx.sv
module mgmt_frame_rx
    import mgmt_bridge_pkg::*;
#(
    parameter int PHY_ADDR     = 0,
    parameter int PREAMBLE_MIN = 32
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     ce,
    input  logic     mdi,
    output bus_req_t req
);

    localparam int PW = $clog2(PREAMBLE_MIN + 1);
    localparam int CW = $clog2(RESP_SLOTS);
    localparam logic [PW-1:0] PRE_TOP   = PW'(PREAMBLE_MIN);
    localparam logic [CW-1:0] OP_LAST   = CW'(1);
    localparam logic [CW-1:0] PHY_LAST  = CW'(PHY_AW - 1);
    localparam logic [CW-1:0] REG_LAST  = CW'(REG_AW - 1);
    localparam logic [CW-1:0] DATA_LAST = CW'(DATA_W - 1);
    localparam logic [CW-1:0] RESP_LAST = CW'(RESP_SLOTS - 1);

    rx_state_e         state;
    logic [PW-1:0]     ones;
    logic [CW-1:0]     cnt;
    logic [1:0]        op_q;
    logic [PHY_AW-1:0] phy_q;
    logic [REG_AW-1:0] reg_q;
    logic [DATA_W-1:0] wd_q;

    logic [1:0]        op_n;
    logic [PHY_AW-1:0] phy_n;
    logic [REG_AW-1:0] reg_n;
    logic [DATA_W-1:0] wd_n;

    assign op_n  = {op_q[0], mdi};
    assign phy_n = {phy_q[PHY_AW-2:0], mdi};
    assign reg_n = {reg_q[REG_AW-2:0], mdi};
    assign wd_n  = {wd_q[DATA_W-2:0], mdi};

    // Requests fire on the very strobe that completes the field.
    always_comb begin
        req       = '0;
        req.addr  = (state == S_REG) ? reg_n : reg_q;
        req.wdata = wd_n;
        req.rd    = ce && (state == S_REG) && (cnt == REG_LAST) && (op_q == OP_RD);
        req.wr    = ce && (state == S_WDATA) && (cnt == DATA_LAST);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= S_HUNT;
            ones  <= '0;
            cnt   <= '0;
            op_q  <= '0;
            phy_q <= '0;
            reg_q <= '0;
            wd_q  <= '0;
        end else if (ce) begin
            case (state)
                S_HUNT: begin
                    if (mdi) begin
                        if (ones != PRE_TOP) ones <= ones + 1'b1;
                    end else begin
                        if (ones == PRE_TOP) state <= S_START;
                        ones <= '0;
                    end
                end
                S_START: begin
                    cnt   <= '0;
                    state <= mdi ? S_OP : S_HUNT;
                end
                S_OP: begin
                    op_q <= op_n;
                    if (cnt == OP_LAST) begin
                        cnt   <= '0;
                        state <= op_known(op_n) ? S_PHY : S_HUNT;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                S_PHY: begin
                    phy_q <= phy_n;
                    if (cnt == PHY_LAST) begin
                        cnt   <= '0;
                        state <= (phy_n == PHY_AW'(PHY_ADDR)) ? S_REG : S_HUNT;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                S_REG: begin
                    reg_q <= reg_n;
                    if (cnt == REG_LAST) begin
                        cnt   <= '0;
                        state <= (op_q == OP_RD) ? S_RESP : S_TA;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                S_TA: begin
                    if (cnt == OP_LAST) begin
                        cnt   <= '0;
                        state <= S_WDATA;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                S_WDATA: begin
                    wd_q <= wd_n;
                    if (cnt == DATA_LAST) begin
                        cnt   <= '0;
                        state <= S_HUNT;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                S_RESP: begin
                    if (cnt == RESP_LAST) begin
                        cnt   <= '0;
                        state <= S_HUNT;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: state <= S_HUNT;
            endcase
        end
    end

endmodule

// File: rtl/mgmt_bus_ctl.sv
module mgmt_bus_ctl
    import mgmt_bridge_pkg::*;
#(
    parameter int ACK_TIMEOUT = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  bus_req_t          req,
    input  logic              abort,
    input  logic              ack,
    input  logic              err,
    input  logic [DATA_W-1:0] data_read,
    output logic              cyc,
    output logic              we,
    output logic [REG_AW-1:0] addr,
    output logic [DATA_W-1:0] wdata,
    output rd_result_t        res
);

    localparam int TW = $clog2(ACK_TIMEOUT + 1);
    localparam logic [TW-1:0] T_LAST = TW'(ACK_TIMEOUT - 1);

    logic [TW-1:0]     timer;
    logic              ok_q;
    logic [DATA_W-1:0] data_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cyc    <= 1'b0;
            we     <= 1'b0;
            addr   <= '0;
            wdata  <= '0;
            timer  <= '0;
            ok_q   <= 1'b0;
            data_q <= '0;
        end else if (req.rd || req.wr) begin
            cyc   <= 1'b1;
            we    <= req.wr;
            addr  <= req.addr;
            wdata <= req.wdata;
            timer <= '0;
            if (req.rd) ok_q <= 1'b0;
        end else if (cyc) begin
            if (ack) begin
                cyc <= 1'b0;
                if (!we) begin
                    ok_q   <= 1'b1;
                    data_q <= data_read;
                end
            end else if (err || abort || (timer == T_LAST)) begin
                cyc <= 1'b0;
            end else begin
                timer <= timer + 1'b1;
            end
        end
    end

    // An acknowledge landing on the decision edge still counts.
    always_comb begin
        res.ok   = ok_q || (cyc && !we && ack);
        res.data = ok_q ? data_q : data_read;
    end

endmodule

// File: rtl/mgmt_resp_tx.sv
module mgmt_resp_tx
    import mgmt_bridge_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       ce,
    input  logic       start,
    input  rd_result_t res,
    output logic       abort,
    output logic       mdo,
    output logic       mdo_valid
);

    localparam int CW = $clog2(RESP_SLOTS);
    localparam logic [CW-1:0] SLOT_LAST = CW'(RESP_SLOTS - 1);

    logic              active;
    logic              good;
    logic [CW-1:0]     slot;
    logic [DATA_W-1:0] sh;

    assign abort = ce && active && (slot == '0) && !res.ok;

    always_ff @(posedge clk) begin
        if (rst) begin
            active    <= 1'b0;
            good      <= 1'b0;
            slot      <= '0;
            sh        <= '0;
            mdo       <= 1'b0;
            mdo_valid <= 1'b0;
        end else if (start) begin
            active    <= 1'b1;
            good      <= 1'b0;
            slot      <= '0;
            mdo       <= 1'b0;
            mdo_valid <= 1'b0;
        end else if (ce && active) begin
            slot <= slot + 1'b1;
            if (slot == '0) begin
                good      <= res.ok;
                sh        <= res.data;
                mdo       <= 1'b0;
                mdo_valid <= res.ok;
            end else if (slot == SLOT_LAST) begin
                active    <= 1'b0;
                mdo       <= 1'b0;
                mdo_valid <= 1'b0;
            end else begin
                mdo       <= sh[DATA_W-1];
                mdo_valid <= good;
                sh        <= {sh[DATA_W-2:0], 1'b0};
            end
        end
    end

endmodule

// File: rtl/mgmt_serial_bridge.sv
module mgmt_serial_bridge
    import mgmt_bridge_pkg::*;
#(
    parameter int PHY_ADDR     = 0,
    parameter int PREAMBLE_MIN = 32,
    parameter int ACK_TIMEOUT  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ce,
    input  logic              mdi,
    output logic              mdo,
    output logic              mdo_valid,
    output logic              cyc,
    output logic              stb,
    output logic              we,
    output logic [REG_AW-1:0] addr,
    output logic [DATA_W-1:0] data_write,
    input  logic [DATA_W-1:0] data_read,
    input  logic              ack,
    input  logic              err
);

    bus_req_t   req;
    rd_result_t res;
    logic       abort;
    logic       cyc_i;

    mgmt_frame_rx #(
        .PHY_ADDR    (PHY_ADDR),
        .PREAMBLE_MIN(PREAMBLE_MIN)
    ) u_rx (
        .clk(clk),
        .rst(rst),
        .ce (ce),
        .mdi(mdi),
        .req(req)
    );

    mgmt_bus_ctl #(
        .ACK_TIMEOUT(ACK_TIMEOUT)
    ) u_bus (
        .clk      (clk),
        .rst      (rst),
        .req      (req),
        .abort    (abort),
        .ack      (ack),
        .err      (err),
        .data_read(data_read),
        .cyc      (cyc_i),
        .we       (we),
        .addr     (addr),
        .wdata    (data_write),
        .res      (res)
    );

    mgmt_resp_tx u_tx (
        .clk      (clk),
        .rst      (rst),
        .ce       (ce),
        .start    (req.rd),
        .res      (res),
        .abort    (abort),
        .mdo      (mdo),
        .mdo_valid(mdo_valid)
    );

    assign cyc = cyc_i;
    assign stb = cyc_i;

endmodule

// File: rtl/mgmt_bridge_chk.sv
module mgmt_bridge_chk #(
    parameter int ACK_TIMEOUT = 16
) (
    input logic        clk,
    input logic        rst,
    input logic        ce,
    input logic        mdo,
    input logic        mdo_valid,
    input logic        cyc,
    input logic        stb,
    input logic        we,
    input logic [4:0]  addr,
    input logic [15:0] data_write,
    input logic        ack,
    input logic        err
);

    int unsigned cyc_len;

    always_ff @(posedge clk) begin
        if (rst || !cyc) cyc_len <= 0;
        else             cyc_len <= cyc_len + 1;
    end

    AST_OUT_ON_STROBE: assert property (@(posedge clk) disable iff (rst)
        !ce |=> ($stable(mdo_valid) && $stable(mdo)));                      // R1

    AST_LEAD_ZERO: assert property (@(posedge clk) disable iff (rst)
        $rose(mdo_valid) |-> !mdo);                                         // R8

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
        (stb && !ack && !err) |=> (!stb || ($stable(addr) && $stable(we) && $stable(data_write)))); // R6

    AST_DROP_ON_RESP: assert property (@(posedge clk) disable iff (rst)
        (stb && (ack || err)) |=> !stb);                                    // R10

    AST_CYC_BOUNDED: assert property (@(posedge clk) disable iff (rst)
        cyc_len <= ACK_TIMEOUT);                                            // R10

endmodule

bind mgmt_serial_bridge mgmt_bridge_chk #(.ACK_TIMEOUT(ACK_TIMEOUT)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .ce        (ce),
    .mdo       (mdo),
    .mdo_valid (mdo_valid),
    .cyc       (cyc),
    .stb       (stb),
    .we        (we),
    .addr      (addr),
    .data_write(data_write),
    .ack       (ack),
    .err       (err)
);

// File: tb/tb_mgmt_serial_bridge.sv
module tb_mgmt_serial_bridge;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ce  = 1'b0;
    logic        mdi = 1'b1;
    logic        ack = 1'b0;
    logic        err = 1'b0;
    logic [15:0] data_read = '0;
    logic        mdo, mdo_valid, cyc, stb, we;
    logic [4:0]  addr;
    logic [15:0] data_write;

    mgmt_serial_bridge dut (
        .clk(clk), .rst(rst), .ce(ce), .mdi(mdi), .mdo(mdo), .mdo_valid(mdo_valid),
        .cyc(cyc), .stb(stb), .we(we), .addr(addr), .data_write(data_write),
        .data_read(data_read), .ack(ack), .err(err)
    );

    always #5 clk = ~clk;

    int n_checks = 0;
    int n_fail   = 0;

    // Bus target: 0 = acknowledge, 1 = error, 2 = silent
    int          resp_mode = 0;
    int          bus_starts = 0;
    logic        last_we;
    logic [4:0]  last_addr;
    logic [15:0] last_dw;
    logic        cyc_prev = 1'b0;
    logic [15:0] regs [32];

    always @(negedge clk) begin
        if (rst) begin
            for (int i = 0; i < 32; i++) regs[i] = 16'h1000 + 16'(i);
        end else if (ack || err) begin
            ack = 1'b0;
            err = 1'b0;
        end else if (cyc && stb && resp_mode != 2) begin
            if (resp_mode == 0) begin
                ack       = 1'b1;
                data_read = regs[addr];
                if (we) regs[addr] = data_write;
            end else begin
                err = 1'b1;
            end
        end
        if (cyc && !cyc_prev) begin
            bus_starts++;
            last_we   = we;
            last_addr = addr;
            last_dw   = data_write;
        end
        cyc_prev = cyc;
    end

    // Expected register contents, kept apart from the target above
    logic [15:0] model [32];

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    logic s_mdo, s_val;

    task automatic bitp(input logic b);
        @(negedge clk);
        mdi = b;
        ce  = 1'b1;
        @(negedge clk);
        ce    = 1'b0;
        mdi   = ~b;
        s_mdo = mdo;
        s_val = mdo_valid;
        @(negedge clk);
    endtask

    task automatic send_hdr(input int pre, input logic [1:0] st, input logic [1:0] op,
                            input logic [4:0] phy, input logic [4:0] ra);
        bitp(1'b0);
        repeat (pre) bitp(1'b1);
        for (int i = 1; i >= 0; i--) bitp(st[i]);
        for (int i = 1; i >= 0; i--) bitp(op[i]);
        for (int i = 4; i >= 0; i--) bitp(phy[i]);
        for (int i = 4; i >= 0; i--) bitp(ra[i]);
    endtask

    task automatic do_write(input int pre, input logic [1:0] st, input logic [1:0] op,
                            input logic [4:0] phy, input logic [4:0] ra, input logic [15:0] d);
        send_hdr(pre, st, op, phy, ra);
        bitp(1'b1);
        bitp(1'b0);
        for (int i = 15; i >= 0; i--) bitp(d[i]);
        repeat (4) @(negedge clk);
    endtask

    task automatic do_read(input int pre, input logic [1:0] st, input logic [1:0] op,
                           input logic [4:0] phy, input logic [4:0] ra,
                           output logic [15:0] val, output int nvalid, output bit shape);
        bit v1;
        send_hdr(pre, st, op, phy, ra);
        shape  = (s_val == 1'b0);
        nvalid = 0;
        val    = '0;
        v1     = 1'b0;
        for (int k = 1; k <= 18; k++) begin
            bitp(1'b1);
            if (s_val) nvalid++;
            if (k == 1) begin
                v1 = s_val;
                if (s_val && s_mdo) shape = 1'b0;
            end else if (k <= 17) begin
                if (s_val != v1) shape = 1'b0;
                val = {val[14:0], s_mdo};
            end else if (s_val) begin
                shape = 1'b0;
            end
        end
    endtask

    task automatic good_read(input int pre, input logic [4:0] ra, input string tag);
        logic [15:0] v;
        int          nv;
        bit          sh;
        int          b0;
        b0 = bus_starts;
        do_read(pre, 2'b01, 2'b10, 5'd0, ra, v, nv, sh);
        chk(bus_starts == b0 + 1 && !last_we && last_addr == ra,
            {tag, " R7 read cycle"}, {last_we, 3'b0, last_addr}, {4'b0, ra});
        chk(nv == 17 && sh, {tag, " R8 reply shape"}, nv, 17);
        chk(v == model[ra], {tag, " R8 reply data"}, v, model[ra]);
        chk(!cyc, {tag, " R11 bus idle after reply"}, cyc, 0);
    endtask

    task automatic good_write(input int pre, input logic [4:0] ra, input logic [15:0] d, input string tag);
        int b0;
        b0 = bus_starts;
        do_write(pre, 2'b01, 2'b01, 5'd0, ra, d);
        chk(bus_starts == b0 + 1 && last_we && last_addr == ra && last_dw == d,
            {tag, " R6 write cycle"}, {last_we, 10'b0, last_addr, last_dw}, {1'b1, 10'b0, ra, d});
        model[ra] = d;
    endtask

    task automatic bad_pair(input int pre, input logic [1:0] st, input logic [1:0] op,
                            input logic [4:0] phy, input string tag);
        logic [15:0] v;
        int          nv;
        bit          sh;
        int          b0;
        b0 = bus_starts;
        do_read(pre, st, op, phy, 5'd7, v, nv, sh);
        chk(bus_starts == b0 && nv == 0, {tag, " read ignored"}, nv, 0);
        do_write(pre, st, op, phy, 5'd7, 16'hDEAD);
        chk(bus_starts == b0, {tag, " write ignored"}, bus_starts - b0, 0);
    endtask

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        #2_000_000;
        n_fail++;
        $display("FAIL R11 watchdog actual=running expected=done");
        finish_run();
    end

    initial begin
        logic [15:0] v;
        int          nv;
        bit          sh;
        int          b0;
        logic [4:0]  ra;
        logic [15:0] d;

        void'($urandom(32'h5EED));
        for (int i = 0; i < 32; i++) model[i] = 16'h1000 + 16'(i);

        repeat (5) @(negedge clk);
        chk(!cyc && !stb && !mdo_valid, "R12 reset outputs", {cyc, stb, mdo_valid}, 0);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        chk(!cyc && !mdo_valid, "R12 idle after reset", {cyc, mdo_valid}, 0);

        // R1: a full write frame presented with ce held low
        b0 = bus_starts;
        repeat (40) @(negedge clk) mdi = 1'b1;
        @(negedge clk) mdi = 1'b0;
        @(negedge clk) mdi = 1'b1;
        for (int i = 0; i < 30; i++) @(negedge clk) mdi = i[0];
        repeat (5) @(negedge clk);
        chk(bus_starts == b0, "R1 no sampling without ce", bus_starts - b0, 0);

        good_write(32, 5'd3, 16'hA5C3, "directed");
        good_read(32, 5'd3, "R1 directed");

        for (int n = 0; n < 10; n++) begin
            ra = 5'($urandom % 32);
            d  = 16'($urandom);
            good_write(32 + int'($urandom % 8), ra, d, "random");
            ra = 5'($urandom % 32);
            good_read(32 + int'($urandom % 8), ra, "random");
        end

        good_read(45, 5'd31, "R2 long preamble");
        bad_pair(31, 2'b01, 2'b10, 5'd0, "R2 short preamble");
        bad_pair(32, 2'b00, 2'b10, 5'd0, "R3 start 00");
        bad_pair(32, 2'b11, 2'b10, 5'd0, "R3 start 11");
        bad_pair(32, 2'b01, 2'b00, 5'd0, "R4 opcode 00");
        bad_pair(32, 2'b01, 2'b11, 5'd0, "R4 opcode 11");
        bad_pair(32, 2'b01, 2'b10, 5'd1, "R5 address 1");
        bad_pair(32, 2'b01, 2'b10, 5'd16, "R5 address 16");
        good_read(32, 5'd7, "R11 after rejects");

        // R9: error response
        resp_mode = 1;
        b0 = bus_starts;
        do_read(32, 2'b01, 2'b10, 5'd0, 5'd5, v, nv, sh);
        chk(bus_starts == b0 + 1 && nv == 0, "R9 error read released", nv, 0);
        do_write(32, 2'b01, 2'b01, 5'd0, 5'd5, 16'h1234);
        chk(!cyc, "R10 error ends write", cyc, 0);

        // R9/R10: silent target
        resp_mode = 2;
        b0 = bus_starts;
        do_read(32, 2'b01, 2'b10, 5'd0, 5'd6, v, nv, sh);
        chk(bus_starts == b0 + 1 && nv == 0, "R9 no-ack read released", nv, 0);
        chk(!cyc && !stb, "R10 read strobe withdrawn", {cyc, stb}, 0);
        do_write(32, 2'b01, 2'b01, 5'd0, 5'd6, 16'h5678);
        repeat (20) @(negedge clk);
        chk(!cyc && !stb, "R10 write timed out", {cyc, stb}, 0);

        resp_mode = 0;
        good_read(32, 5'd5, "R11 after error");
        good_read(32, 5'd6, "R11 after timeout");

        finish_run();
    end

endmodule